// File: doc/BRIEF.md
# Predicate Register Load Unit

This block carries out a single load-predicate operation for a vector engine. A request brings a byte address, an address-space tag, the active element-type context and a post-update flag. The unit checks the request. When the request is legal, it issues one 64-bit read to the local scratchpad. When the read data returns, it writes that data into a 256-bit predicate register in one cycle and clears every bit above the loaded word.

An illegal request never reaches the scratchpad. The unit then reports one exception code, chosen by a fixed priority, and leaves the predicate register as it was. Every operation ends with a one-cycle completion pulse. In post-update mode that completion also returns the base address advanced by one word. Only one load is outstanding at a time. The unit does no fencing, and it never saves or clears the previous predicate.

Top module: `pred_ld_unit`

## Requirements
- R1: While reset is asserted and after it is released, the unit shows `pred_o` all zeros, `done_o` low, `rd_req_o` low and `req_ready_o` high.
- R2: `req_ready_o` is high only when no load is outstanding. A request is taken when `req_valid_i` and `req_ready_o` are both high at a clock edge, and `req_ready_o` stays low until that load has completed.
- R3: A legal request raises `rd_req_o` in the cycle after acceptance, with `rd_addr_o` equal to the request address. Both stay unchanged until a cycle in which `rd_rsp_valid_i` is high, and exactly one read is made.
- R4: On the edge where `rd_rsp_valid_i` is seen during a read, `pred_o[63:0]` takes `rd_rsp_data_i` and `pred_o[255:64]` becomes zero. In the following cycle `done_o` is high for one cycle with `exc_o` = 0.
- R5: A space tag other than the local scratchpad tag (2'd1) gives exception code 1. This check has the highest priority.
- R6: With a legal space, an address whose low three bits are nonzero gives exception code 2. This check ranks above the width check.
- R7: With a legal space and alignment, an element-type context other than f32 (0 = f32, 1 = f16/bf16, 2 = i8/u8, 3 = reserved) gives exception code 3.
- R8: A request that raises an exception makes no scratchpad read and does not change `pred_o`. `done_o` is high, with `exc_o` holding the code, in the cycle right after acceptance.
- R9: With the post-update flag set on a successful load, `base_upd_valid_o` is high together with `done_o`, and `base_upd_o` equals the address plus 8 (wrapping modulo 2^32). `base_upd_valid_o` stays low when the flag is clear or when an exception is raised.
- R10: While a read is waiting for its response, `pred_o` keeps its previous value. It is neither cleared nor changed before the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit idle, request can be accepted |
| req_addr_i | input | 32 | Byte address of the predicate word |
| req_space_i | input | 2 | Address-space tag, 1 = local scratchpad |
| req_etype_i | input | 2 | Element-type context: 0 f32, 1 f16/bf16, 2 i8/u8, 3 reserved |
| req_post_i | input | 1 | Post-update mode |
| rd_req_o | output | 1 | Scratchpad read request, held until response |
| rd_addr_o | output | 32 | Scratchpad read address |
| rd_rsp_valid_i | input | 1 | Scratchpad read data valid |
| rd_rsp_data_i | input | 64 | Scratchpad read data |
| pred_o | output | 256 | Predicate register |
| done_o | output | 1 | One-cycle completion pulse |
| exc_o | output | 2 | Exception code, valid with done_o (0 none, 1 space, 2 alignment, 3 width) |
| base_upd_valid_o | output | 1 | Updated base is valid |
| base_upd_o | output | 32 | Base address plus 8 |

## Verification
The assertions assume that the scratchpad raises `rd_rsp_valid_i` only while `rd_req_o` is high, and only once for each read. They also assume that a requester keeps `req_valid_i` high only for the cycle in which it is accepted. The bench drives responses only after it has seen `rd_req_o` high, pulses the response for exactly one cycle, and drops `req_valid_i` right after the accepting edge. Random requests are biased toward legal tags, legal alignment and the f32 context, so that every exception code and every commit path is reached. Response latencies vary from zero to several cycles.

// File: rtl/pred_ld_pkg.sv
package pred_ld_pkg;
  typedef enum logic [1:0] {
    ET_F32  = 2'd0,
    ET_F16  = 2'd1,
    ET_I8   = 2'd2,
    ET_RSVD = 2'd3
  } elem_e;

  typedef enum logic [1:0] {
    EXC_NONE  = 2'd0,
    EXC_SPACE = 2'd1,
    EXC_ALIGN = 2'd2,
    EXC_WIDTH = 2'd3
  } exc_e;

  // active predicate width in bits for a context; 0 for reserved
  function automatic int unsigned pred_width(elem_e et);
    case (et)
      ET_F32:  return 64;
      ET_F16:  return 128;
      ET_I8:   return 256;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/pred_ld_check.sv
module pred_ld_check
  import pred_ld_pkg::*;
#(
  parameter int unsigned SW          = 2,
  parameter int unsigned WORD_W      = 64,
  parameter logic [SW-1:0] LOCAL_SPACE = 1,
  localparam int unsigned ALIGN_LSB  = $clog2(WORD_W / 8)
) (
  input  logic [ALIGN_LSB-1:0] addr_lo_i,
  input  logic [SW-1:0]        space_i,
  input  logic [1:0]           etype_i,
  output logic [1:0]           exc_o
);
  // fixed priority: space, alignment, width
  always_comb begin
    if (space_i != LOCAL_SPACE)                     exc_o = EXC_SPACE;
    else if (addr_lo_i != '0)                       exc_o = EXC_ALIGN;
    else if (pred_width(elem_e'(etype_i)) != WORD_W) exc_o = EXC_WIDTH;
    else                                            exc_o = EXC_NONE;
  end
endmodule

// File: rtl/pred_ld_ctrl.sv
module pred_ld_ctrl
  import pred_ld_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned WORD_W = 64,
  localparam int unsigned WORD_BYTES = WORD_W / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_post_i,
  input  logic [1:0]    chk_exc_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_rsp_valid_i,
  output logic          commit_o,
  output logic          done_o,
  output logic [1:0]    exc_o,
  output logic          base_upd_valid_o,
  output logic [AW-1:0] base_upd_o
);
  typedef enum logic {ST_IDLE, ST_READ} state_e;

  state_e        state_q;
  logic [AW-1:0] addr_q, upd_q;
  logic          post_q, done_q, upd_v_q;
  logic [1:0]    exc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      post_q  <= 1'b0;
      done_q  <= 1'b0;
      exc_q   <= EXC_NONE;
      upd_v_q <= 1'b0;
      upd_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      exc_q   <= EXC_NONE;
      upd_v_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          addr_q <= req_addr_i;
          post_q <= req_post_i;
          if (chk_exc_i != EXC_NONE) begin
            done_q <= 1'b1;
            exc_q  <= chk_exc_i;
          end else begin
            state_q <= ST_READ;
          end
        end
        ST_READ: if (rd_rsp_valid_i) begin
          done_q  <= 1'b1;
          upd_v_q <= post_q;
          upd_q   <= addr_q + AW'(WORD_BYTES);
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o      = (state_q == ST_IDLE);
  assign rd_req_o         = (state_q == ST_READ);
  assign rd_addr_o        = addr_q;
  assign commit_o         = (state_q == ST_READ) && rd_rsp_valid_i;
  assign done_o           = done_q;
  assign exc_o            = exc_q;
  assign base_upd_valid_o = upd_v_q;
  assign base_upd_o       = upd_q;
endmodule

// File: rtl/pred_ld_reg.sv
module pred_ld_reg #(
  parameter int unsigned PRED_W = 256,
  parameter int unsigned WORD_W = 64,
  localparam int unsigned LANES = PRED_W / WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [PRED_W-1:0] pred_o
);
  // lane 0 takes the loaded word; upper lanes are zero-filled on commit
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WORD_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lane_q <= '0;
      else if (commit_i) lane_q <= (l == 0) ? data_i : '0;
    end
    assign pred_o[l*WORD_W +: WORD_W] = lane_q;
  end
endmodule

// File: rtl/pred_ld_unit.sv
module pred_ld_unit
  import pred_ld_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned SW     = 2,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned PRED_W = 256,
  parameter logic [SW-1:0] LOCAL_SPACE = 1,
  localparam int unsigned ALIGN_LSB = $clog2(WORD_W / 8)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [SW-1:0]     req_space_i,
  input  logic [1:0]        req_etype_i,
  input  logic              req_post_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_rsp_valid_i,
  input  logic [WORD_W-1:0] rd_rsp_data_i,
  output logic [PRED_W-1:0] pred_o,
  output logic              done_o,
  output logic [1:0]        exc_o,
  output logic              base_upd_valid_o,
  output logic [AW-1:0]     base_upd_o
);
  logic [1:0] chk_exc;
  logic       commit;

  pred_ld_check #(.SW(SW), .WORD_W(WORD_W), .LOCAL_SPACE(LOCAL_SPACE)) u_check (
    .addr_lo_i (req_addr_i[ALIGN_LSB-1:0]),
    .space_i   (req_space_i),
    .etype_i   (req_etype_i),
    .exc_o     (chk_exc)
  );

  pred_ld_ctrl #(.AW(AW), .WORD_W(WORD_W)) u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .req_valid_i      (req_valid_i),
    .req_ready_o      (req_ready_o),
    .req_addr_i       (req_addr_i),
    .req_post_i       (req_post_i),
    .chk_exc_i        (chk_exc),
    .rd_req_o         (rd_req_o),
    .rd_addr_o        (rd_addr_o),
    .rd_rsp_valid_i   (rd_rsp_valid_i),
    .commit_o         (commit),
    .done_o           (done_o),
    .exc_o            (exc_o),
    .base_upd_valid_o (base_upd_valid_o),
    .base_upd_o       (base_upd_o)
  );

  pred_ld_reg #(.PRED_W(PRED_W), .WORD_W(WORD_W)) u_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .data_i   (rd_rsp_data_i),
    .pred_o   (pred_o)
  );
endmodule

// File: rtl/pred_ld_unit_chk.sv
module pred_ld_unit_chk #(
  parameter int unsigned AW     = 32,
  parameter int unsigned WORD_W = 64,
  parameter int unsigned PRED_W = 256,
  localparam int unsigned ALIGN_LSB = $clog2(WORD_W / 8)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rd_req_o,
  input logic [AW-1:0]     rd_addr_o,
  input logic              rd_rsp_valid_i,
  input logic [WORD_W-1:0] rd_rsp_data_i,
  input logic [PRED_W-1:0] pred_o,
  input logic              done_o,
  input logic [1:0]        exc_o,
  input logic              base_upd_valid_o
);
  p_one_in_flight_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> !req_ready_o);

  p_read_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_rsp_valid_i |=> rd_req_o && $stable(rd_addr_o));

  p_read_aligned_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> rd_addr_o[ALIGN_LSB-1:0] == '0);

  p_commit_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && exc_o == 2'd0 |-> $past(rd_req_o && rd_rsp_valid_i)
                                && pred_o[WORD_W-1:0] == $past(rd_rsp_data_i));

  p_upper_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_o[PRED_W-1:WORD_W] == '0);

  p_no_write_on_fault_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pred_o) |-> done_o && exc_o == 2'd0);

  p_exc_with_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o != 2'd0 |-> done_o);

  p_upd_only_ok_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    base_upd_valid_o |-> done_o && exc_o == 2'd0);

  p_pred_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_rsp_valid_i |=> $stable(pred_o));
endmodule

bind pred_ld_unit pred_ld_unit_chk #(.AW(AW), .WORD_W(WORD_W), .PRED_W(PRED_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .req_ready_o      (req_ready_o),
  .rd_req_o         (rd_req_o),
  .rd_addr_o        (rd_addr_o),
  .rd_rsp_valid_i   (rd_rsp_valid_i),
  .rd_rsp_data_i    (rd_rsp_data_i),
  .pred_o           (pred_o),
  .done_o           (done_o),
  .exc_o            (exc_o),
  .base_upd_valid_o (base_upd_valid_o)
);

// File: tb/pred_ld_unit_tb.sv
module pred_ld_unit_tb;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic [31:0]  req_addr_i = '0;
  logic [1:0]   req_space_i = '0;
  logic [1:0]   req_etype_i = '0;
  logic         req_post_i = 1'b0;
  logic         rd_req_o;
  logic [31:0]  rd_addr_o;
  logic         rd_rsp_valid_i = 1'b0;
  logic [63:0]  rd_rsp_data_i = '0;
  logic [255:0] pred_o;
  logic         done_o;
  logic [1:0]   exc_o;
  logic         base_upd_valid_o;
  logic [31:0]  base_upd_o;

  int unsigned n_chk = 0, n_fail = 0;
  logic [255:0] exp_pred = '0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  pred_ld_unit u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_exc(logic [31:0] a, logic [1:0] sp, logic [1:0] et);
    if (sp != 2'd1)      return 2'd1;
    if (a[2:0] != 3'd0)  return 2'd2;
    if (et != 2'd0)      return 2'd3;
    return 2'd0;
  endfunction

  task automatic do_op(input logic [31:0] a, input logic [1:0] sp, input logic [1:0] et,
                       input bit post, input logic [63:0] d, input int lat);
    logic [1:0] ee;
    ee = exp_exc(a, sp, et);
    @(negedge clk_i);
    chk(req_ready_o, "R2 ready when idle", 256'(req_ready_o), 256'd1);
    req_valid_i = 1'b1; req_addr_i = a; req_space_i = sp; req_etype_i = et; req_post_i = post;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (ee != 2'd0) begin
      chk(done_o && exc_o == ee, "R5/R6/R7 exception code", 256'(exc_o), 256'(ee));
      chk(!rd_req_o, "R8 no read on fault", 256'(rd_req_o), 256'd0);
      chk(pred_o == exp_pred, "R8 predicate unchanged", pred_o, exp_pred);
      chk(!base_upd_valid_o, "R9 no update on fault", 256'(base_upd_valid_o), 256'd0);
      @(negedge clk_i);
      chk(!done_o, "R8 done single pulse", 256'(done_o), 256'd0);
    end else begin
      chk(rd_req_o && rd_addr_o == a, "R3 read issued", 256'(rd_addr_o), 256'(a));
      chk(!req_ready_o && !done_o, "R2 busy while reading", 256'(req_ready_o), 256'd0);
      for (int i = 0; i < lat; i++) begin
        @(negedge clk_i);
        chk(rd_req_o && rd_addr_o == a, "R3 read held", 256'(rd_addr_o), 256'(a));
        chk(pred_o == exp_pred, "R10 predicate kept while waiting", pred_o, exp_pred);
      end
      rd_rsp_valid_i = 1'b1; rd_rsp_data_i = d;
      @(posedge clk_i);
      @(negedge clk_i);
      rd_rsp_valid_i = 1'b0; rd_rsp_data_i = ~d;
      exp_pred = {192'd0, d};
      chk(done_o && exc_o == 2'd0, "R4 done without exception", 256'(exc_o), 256'd0);
      chk(pred_o == exp_pred, "R4 commit and zero-fill", pred_o, exp_pred);
      chk(!rd_req_o, "R3 single read", 256'(rd_req_o), 256'd0);
      chk(base_upd_valid_o == post, "R9 update valid follows flag", 256'(base_upd_valid_o), 256'(post));
      if (post) chk(base_upd_o == a + 32'd8, "R9 updated base", 256'(base_upd_o), 256'(a + 32'd8));
      @(negedge clk_i);
      chk(!done_o && req_ready_o, "R4 done single pulse", 256'(done_o), 256'd0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] a;
    logic [1:0]  sp, et;
    void'($urandom(32'd2024));
    #5;
    chk(pred_o == '0 && !done_o && !rd_req_o && req_ready_o, "R1 state during reset", pred_o, '0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(pred_o == '0 && !done_o && !rd_req_o && req_ready_o, "R1 state after reset", pred_o, '0);

    // directed corners
    do_op(32'h0000_1000, 2'd1, 2'd0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    do_op(32'h0000_1003, 2'd0, 2'd2, 1'b1, 64'h0, 0);   // R5 wins over align and width
    do_op(32'h0000_1004, 2'd1, 2'd1, 1'b1, 64'h0, 0);   // R6 wins over width
    do_op(32'h0000_2000, 2'd1, 2'd1, 1'b0, 64'h0, 0);   // R7 f16
    do_op(32'h0000_2000, 2'd1, 2'd2, 1'b0, 64'h0, 0);   // R7 i8
    do_op(32'h0000_2000, 2'd1, 2'd3, 1'b1, 64'h0, 0);   // R7 reserved
    do_op(32'h0000_2000, 2'd3, 2'd0, 1'b1, 64'h0, 0);   // R5 other tag
    do_op(32'hFFFF_FFF8, 2'd1, 2'd0, 1'b1, 64'hA5A5_0000_1234_5678, 4); // R9 wrap
    do_op(32'h0000_0040, 2'd1, 2'd0, 1'b0, 64'h0, 2);   // R4 zero load
    do_op(32'h0000_0001, 2'd1, 2'd0, 1'b1, 64'h0, 0);   // R6 single low bit

    for (int n = 0; n < 400; n++) begin
      a  = $urandom;
      if ($urandom_range(9) < 8) a[2:0] = 3'd0;
      sp = ($urandom_range(9) < 8) ? 2'd1 : 2'($urandom_range(3));
      et = ($urandom_range(9) < 7) ? 2'd0 : 2'($urandom_range(3));
      do_op(a, sp, et, 1'($urandom_range(1)), {$urandom, $urandom}, $urandom_range(5));
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule